// File: doc/BRIEF.md
# Tone Transceiver Bus Register Block

This block is the processor-facing side of a tone transceiver. A narrow bus with one register-select line, single-cycle read and write strobes and a 4-bit data path reaches five registers: a write-only transmit code register, a read-only receive code register, a status register and two control registers that share a single control address. A pointer bit in the first control register sends exactly one following control write to the second control register. After that write, control writes return to the first register.

The control bits are decoded into mode outputs for the tone generator, filters and burst timer. Those engines are outside this block and connect only through strobes: a received-code valid pulse with its code, a transmitter-ready pulse, the rectangular call-progress detect level and the delayed-steering level. The active-low interrupt pin is multiplexed among three sources: the latched interrupt flag, the call-progress detect signal and the inverted delayed-steering signal in test mode.

Top module: `tone_xcvr_regs`

## Requirements
- R1: After reset, both control registers are zero, the pointer selects control register A, the interrupt flag, receive-full and overrun bits are 0, transmit-empty is 1, burst mode is enabled (burst_en_o = 1) and irq_n_o is 1.
- R2: With sel_i = 0, a write loads the transmit code and a read returns the receive code. With sel_i = 1, a write goes to a control register and a read returns status. The status bits are: bit 0 interrupt flag, bit 1 transmit empty, bit 2 receive full, bit 3 receive overrun. rdata_o follows the addressed register combinationally.
- R3: Control register A decodes as: bit 0 to tone_en_o, bit 1 to cp_mode_o (1 = call progress, 0 = DTMF), bit 2 to the interrupt enable. Writing A with bit 3 = 1 routes only the next control write to B.
- R4: Control register B decodes as: bit 0 = 0 enables burst mode (burst_en_o = 1), bit 1 to test_mode_o, bit 2 to single_tone_o, bit 3 to col_sel_o.
- R5: A transmit write latches the code on tx_code_o, pulses tx_load_o high in the following cycle and clears transmit-empty. tx_ready_pulse_i sets transmit-empty. A transmit write in the same cycle takes precedence.
- R6: rx_valid_i latches rx_code_i and sets receive-full. A receive read clears receive-full, and a new valid pulse in the same cycle wins. A valid pulse while receive-full is set and not being read sets the overrun bit.
- R7: With the interrupt enable set and DTMF mode selected, the interrupt flag is set by rx_valid_i, or by tx_ready_pulse_i when burst mode is on. A status read clears the flag and the overrun bit. A set in the same cycle wins.
- R8: The pin source has this priority. If test mode is on and DTMF mode is selected, the pin carries the inverse of steer_dly_i. Otherwise, if interrupts are enabled in call-progress mode, it carries cp_detect_i. Otherwise, if interrupts are enabled, it carries the inverse of the interrupt flag. In all other cases the pin is 1.
- R9: With PIN_REG = 1, irq_n_o is registered and shows the source value from the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register select: 0 data, 1 control/status |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data |
| rx_valid_i | input | 1 | Pulse: receiver has a valid code |
| rx_code_i | input | 4 | Received tone code |
| tx_ready_pulse_i | input | 1 | Pulse: transmitter ready for more data |
| cp_detect_i | input | 1 | Call-progress detect square wave |
| steer_dly_i | input | 1 | Delayed steering level from receiver |
| tx_code_o | output | 4 | Latched transmit code |
| tx_load_o | output | 1 | One-cycle load strobe to burst timer |
| tone_en_o | output | 1 | Tone output enable |
| cp_mode_o | output | 1 | Call-progress mode selected |
| burst_en_o | output | 1 | Burst mode active |
| test_mode_o | output | 1 | Test mode selected |
| single_tone_o | output | 1 | Single-tone generation |
| col_sel_o | output | 1 | Column (1) or row (0) single tone |
| irq_n_o | output | 1 | Active-low interrupt / call-progress / test pin |

## Verification
The bench builds the block with DATA_W = 4 and PIN_REG = 1. With these values the bench reaches the registered-pin timing and every status bit position that the bus exposes. Random control writes often leave the pointer armed, so back-to-back control writes, the single redirect to B and the return to A all occur many times. Strobes collide with reads and writes in the same cycle, which exercises the set-wins and write-wins precedence rules and every branch of the pin priority.

// File: rtl/tone_regs_pkg.sv
package tone_regs_pkg;
  typedef struct packed {
    logic tone_en;
    logic cp_mode;
    logic irq_en;
    logic burst_en;
    logic test_mode;
    logic single_tone;
    logic col_sel;
  } mode_t;

  localparam int unsigned ST_IRQ   = 0;
  localparam int unsigned ST_TXE   = 1;
  localparam int unsigned ST_RXF   = 2;
  localparam int unsigned ST_OVR   = 3;
endpackage

// File: rtl/tone_ctrl_regs.sv
module tone_ctrl_regs
  import tone_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_t             mode_o,
  output logic              ptr_b_o
);
  logic [DATA_W-1:0] cra_q, crb_q;
  logic              ptr_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cra_q   <= '0;
      crb_q   <= '0;
      ptr_b_q <= 1'b0;
    end else if (wr_ctrl_i) begin
      if (ptr_b_q) begin
        crb_q   <= wdata_i;
        ptr_b_q <= 1'b0;
      end else begin
        cra_q   <= wdata_i;
        ptr_b_q <= wdata_i[3];
      end
    end
  end

  always_comb begin
    mode_o.tone_en     = cra_q[0];
    mode_o.cp_mode     = cra_q[1];
    mode_o.irq_en      = cra_q[2];
    mode_o.burst_en    = ~crb_q[0];
    mode_o.test_mode   = crb_q[1];
    mode_o.single_tone = crb_q[2];
    mode_o.col_sel     = crb_q[3];
  end
  assign ptr_b_o = ptr_b_q;

  p_ptr_one_shot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_b_q && wr_ctrl_i) |=> !ptr_b_q);
  p_crb_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ptr_b_q && wr_ctrl_i)) |=> $stable(crb_q));
endmodule

// File: rtl/tone_status_regs.sv
module tone_status_regs
  import tone_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_tx_i,
  input  logic              rd_rx_i,
  input  logic              rd_stat_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_code_i,
  input  logic              tx_ready_i,
  input  mode_t             mode_i,
  output logic [DATA_W-1:0] tx_code_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [3:0]        status_o,
  output logic              irq_flag_o
);
  logic [DATA_W-1:0] tx_q, rx_q;
  logic load_q, txe_q, rxf_q, ovr_q, irq_q;
  logic irq_set;

  assign irq_set = mode_i.irq_en && !mode_i.cp_mode &&
                   (rx_valid_i || (tx_ready_i && mode_i.burst_en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      rx_q   <= '0;
      load_q <= 1'b0;
      txe_q  <= 1'b1;
      rxf_q  <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      load_q <= wr_tx_i;
      if (wr_tx_i) tx_q <= wdata_i;
      if (wr_tx_i)         txe_q <= 1'b0;
      else if (tx_ready_i) txe_q <= 1'b1;
      if (rx_valid_i) rx_q <= rx_code_i;
      if (rx_valid_i)   rxf_q <= 1'b1;
      else if (rd_rx_i) rxf_q <= 1'b0;
      if (rx_valid_i && rxf_q && !rd_rx_i) ovr_q <= 1'b1;
      else if (rd_stat_i)                  ovr_q <= 1'b0;
      if (irq_set)        irq_q <= 1'b1;
      else if (rd_stat_i) irq_q <= 1'b0;
    end
  end

  assign tx_code_o  = tx_q;
  assign tx_load_o  = load_q;
  assign rx_data_o  = rx_q;
  assign irq_flag_o = irq_q;
  always_comb begin
    status_o         = '0;
    status_o[ST_IRQ] = irq_q;
    status_o[ST_TXE] = txe_q;
    status_o[ST_RXF] = rxf_q;
    status_o[ST_OVR] = ovr_q;
  end

  p_tx_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx_i |=> (tx_load_o && !status_o[ST_TXE]));
  p_rx_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx_i && !rx_valid_i) |=> !status_o[ST_RXF]);
  p_irq_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i.irq_en && !mode_i.cp_mode && rx_valid_i) |=> irq_flag_o);
  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !rx_valid_i && !tx_ready_i) |=> !irq_flag_o);
endmodule

// File: rtl/tone_pin_mux.sv
module tone_pin_mux
  import tone_regs_pkg::*;
#(
  parameter bit PIN_REG = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  irq_flag_i,
  input  logic  cp_detect_i,
  input  logic  steer_dly_i,
  output logic  pin_n_o
);
  logic pin_d;

  always_comb begin
    if (mode_i.test_mode && !mode_i.cp_mode) pin_d = ~steer_dly_i;
    else if (mode_i.irq_en && mode_i.cp_mode) pin_d = cp_detect_i;
    else if (mode_i.irq_en)                   pin_d = ~irq_flag_i;
    else                                      pin_d = 1'b1;
  end

  generate
    if (PIN_REG) begin : g_reg
      logic pin_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pin_q <= 1'b1;
        else         pin_q <= pin_d;
      end
      assign pin_n_o = pin_q;

      p_pin_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_i.irq_en && !mode_i.test_mode) |=> pin_n_o);
      p_pin_steer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i.test_mode && !mode_i.cp_mode) |=> (pin_n_o == !$past(steer_dly_i)));
    end else begin : g_comb
      assign pin_n_o = pin_d;
    end
  endgenerate
endmodule

// File: rtl/tone_xcvr_regs.sv
module tone_xcvr_regs
  import tone_regs_pkg::*;
#(
  parameter int unsigned DATA_W  = 4,
  parameter bit          PIN_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_code_i,
  input  logic              tx_ready_pulse_i,
  input  logic              cp_detect_i,
  input  logic              steer_dly_i,
  output logic [DATA_W-1:0] tx_code_o,
  output logic              tx_load_o,
  output logic              tone_en_o,
  output logic              cp_mode_o,
  output logic              burst_en_o,
  output logic              test_mode_o,
  output logic              single_tone_o,
  output logic              col_sel_o,
  output logic              irq_n_o
);
  mode_t             mode;
  logic              ptr_b;
  logic [DATA_W-1:0] rx_data;
  logic [3:0]        status;
  logic              irq_flag;
  logic              wr_tx, wr_ctrl, rd_rx, rd_stat;

  assign wr_tx   = wr_i && !sel_i;
  assign wr_ctrl = wr_i &&  sel_i;
  assign rd_rx   = rd_i && !sel_i;
  assign rd_stat = rd_i &&  sel_i;

  tone_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni, .wr_ctrl_i(wr_ctrl), .wdata_i, .mode_o(mode), .ptr_b_o(ptr_b)
  );

  tone_status_regs #(.DATA_W(DATA_W)) u_stat (
    .clk_i, .rst_ni, .wr_tx_i(wr_tx), .rd_rx_i(rd_rx), .rd_stat_i(rd_stat),
    .wdata_i, .rx_valid_i, .rx_code_i, .tx_ready_i(tx_ready_pulse_i),
    .mode_i(mode), .tx_code_o, .tx_load_o, .rx_data_o(rx_data),
    .status_o(status), .irq_flag_o(irq_flag)
  );

  tone_pin_mux #(.PIN_REG(PIN_REG)) u_pin (
    .clk_i, .rst_ni, .mode_i(mode), .irq_flag_i(irq_flag),
    .cp_detect_i, .steer_dly_i, .pin_n_o(irq_n_o)
  );

  assign rdata_o       = sel_i ? DATA_W'(status) : rx_data;
  assign tone_en_o     = mode.tone_en;
  assign cp_mode_o     = mode.cp_mode;
  assign burst_en_o    = mode.burst_en;
  assign test_mode_o   = mode.test_mode;
  assign single_tone_o = mode.single_tone;
  assign col_sel_o     = mode.col_sel;

  p_ptr_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && !ptr_b && wdata_i[3]) |=> ptr_b);
  p_rd_status_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |-> (rdata_o[ST_TXE] == status[ST_TXE]));
endmodule

// File: tb/tone_xcvr_regs_test.sv
module tone_xcvr_regs_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, rd = 0, wr = 0, rxv = 0, txr = 0, cpd = 0, std = 0;
  logic [DW-1:0] wd = '0, rxc = '0;
  logic [DW-1:0] rdata, tx_code;
  logic tx_load, tone_en, cp_mode, burst_en, test_mode, single_tone, col_sel, irq_n;

  int unsigned n_vec = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [2:0] m_cra = '0;
  logic [3:0] m_crb = '0, m_tx = '0, m_rx = '0;
  logic m_ptr = 0, m_flag = 0, m_txe = 1, m_rxf = 0, m_ovr = 0, m_load = 0, m_pin = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_xcvr_regs #(.DATA_W(DW), .PIN_REG(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr), .wdata_i(wd),
    .rdata_o(rdata), .rx_valid_i(rxv), .rx_code_i(rxc), .tx_ready_pulse_i(txr),
    .cp_detect_i(cpd), .steer_dly_i(std), .tx_code_o(tx_code), .tx_load_o(tx_load),
    .tone_en_o(tone_en), .cp_mode_o(cp_mode), .burst_en_o(burst_en),
    .test_mode_o(test_mode), .single_tone_o(single_tone), .col_sel_o(col_sel),
    .irq_n_o(irq_n)
  );

  function automatic logic [3:0] f_status();
    return {m_ovr, m_rxf, m_txe, m_flag};
  endfunction

  function automatic logic f_pin(logic cpv, logic stv);
    if (m_crb[1] && !m_cra[1]) return ~stv;
    if (m_cra[2] && m_cra[1])  return cpv;
    if (m_cra[2])              return ~m_flag;
    return 1'b1;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_outs();
    chk("R5", {3'b0, tx_load, tx_code}, {3'b0, m_load, m_tx});
    chk("R3", {5'b0, tone_en, cp_mode, 1'b0}, {5'b0, m_cra[0], m_cra[1], 1'b0});
    chk("R4", {4'b0, burst_en, test_mode, single_tone, col_sel},
              {4'b0, ~m_crb[0], m_crb[1], m_crb[2], m_crb[3]});
    chk("R8", {7'b0, irq_n}, {7'b0, m_pin});
  endtask

  // one bus cycle: inputs set after negedge, model updated at posedge
  task automatic step(logic s, logic r, logic w, logic [3:0] d,
                      logic v, logic [3:0] c, logic t, logic cp, logic st);
    logic set_i;
    sel = s; rd = r; wr = w; wd = d; rxv = v; rxc = c; txr = t; cpd = cp; std = st;
    #1;
    if (r) chk("R2", {4'b0, rdata}, {4'b0, s ? f_status() : m_rx});
    @(posedge clk);
    m_pin  = f_pin(cp, st);
    set_i  = m_cra[2] && !m_cra[1] && (v || (t && !m_crb[0]));
    if (v && m_rxf && !(r && !s)) m_ovr = 1;
    else if (r && s)              m_ovr = 0;
    if (set_i)       m_flag = 1;
    else if (r && s) m_flag = 0;
    if (v) begin m_rxf = 1; m_rx = c; end
    else if (r && !s) m_rxf = 0;
    if (w && !s) m_txe = 0; else if (t) m_txe = 1;
    m_load = w && !s;
    if (w && !s) m_tx = d;
    if (w && s) begin
      if (m_ptr) begin m_crb = d; m_ptr = 0; end
      else begin m_cra = d[2:0]; m_ptr = d[3]; end
    end
    @(negedge clk);
    sel = 0; rd = 0; wr = 0; rxv = 0; txr = 0;
    chk_outs();
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk_outs();
    chk("R1", {7'b0, burst_en}, 8'h01);
    sel = 1; #1; chk("R1", {4'b0, rdata}, 8'h02); sel = 0;
    rst_n = 1;
    @(negedge clk);

    // R3: arm pointer, next write to B, following to A
    step(1,0,1,4'b1100, 0,0,0,0,0);  // A: irq_en, ptr
    step(1,0,1,4'b1011, 0,0,0,0,0);  // B: burst off(b0=1), test, column
    step(1,0,1,4'b0101, 0,0,0,0,0);  // back to A
    chk("R3", {5'b0, m_ptr, tone_en, cp_mode}, {5'b0, 1'b0, 1'b1, 1'b0});
    // R8 test mode steering inversion
    step(0,0,0,0, 0,0,0,0,1);
    step(0,0,0,0, 0,0,0,0,0);
    // clear B via pointer
    step(1,0,1,4'b1100, 0,0,0,0,0);
    step(1,0,1,4'b0000, 0,0,0,0,0);
    step(1,0,1,4'b0100, 0,0,0,0,0);
    // R5 tx write and ready
    step(0,0,1,4'h9, 0,0,0,0,0);
    step(1,1,0,0, 0,0,0,0,0);
    step(0,0,0,0, 0,0,1,0,0);       // burst on: R7 flag via tx ready
    step(1,1,0,0, 0,0,0,0,0);       // R7 clear by status read
    // R6 receive, overrun, clear
    step(0,0,0,0, 1,4'h5,0,0,0);
    step(0,0,0,0, 1,4'hA,0,0,0);    // overrun
    step(0,1,0,0, 0,0,0,0,0);
    step(1,1,0,0, 1,4'h3,0,0,0);    // R7 set wins over clear
    step(1,1,0,0, 0,0,0,0,0);
    // R8 call progress passthrough
    step(1,0,1,4'b0110, 0,0,0,1,0);
    step(0,0,0,0, 0,0,0,1,0);
    step(0,0,0,0, 1,4'h7,0,0,0);    // no flag in cp mode

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op = 4'($urandom_range(0, 15));
      logic [3:0] d  = 4'($urandom);
      if (op < 4 && $urandom_range(0,1) == 0) d[3] = 1'b1;
      step(op[0], op[1] && op[2], op[1] && !op[2] || op == 4'hF, d,
           $urandom_range(0,5) == 0, 4'($urandom), $urandom_range(0,5) == 0,
           1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule